// File: doc/BRIEF.md
# Single/Double Floating-Point Format Converter

This block converts one floating-point operand between the 32-bit and 64-bit binary interchange formats in a single combinational pass. It serves the float-to-float conversion instructions of a scalar FPU. The 5-bit source-type field of the instruction (the rs2 slot) and the 2-bit destination-format field (the fmt slot) decide the direction. Code 0 means single and code 1 means double in both fields.

Widening from single to double is always exact and never raises inexact. A single-precision subnormal is normalised into the double format. Narrowing from double to single rounds under one of five rounding modes. Overflow saturates to infinity or to the largest finite value, and results below the normal range are denormalised with correct rounding. NV, OF, UF and NX are raised as needed.

Single-precision values live in the low half of a 64-bit register value. On input, the upper half must be all ones, or the operand counts as the canonical quiet NaN. On output, the upper half is filled with ones.

Top module: `fpFmtCvt`

## Requirements
- R1: Widening happens only when srcType = 0 and dstFmt = 01. Narrowing happens only when srcType = 1 and dstFmt = 00. Every other combination gives result 0 and flags 0.
- R2: A narrowed result has bits 63:32 all ones, and the single value sits in bits 31:0.
- R3: When widening, if bits 63:32 of the operand are not all ones, the operand is taken as the single canonical NaN (0x7FC00000). The result is then the double canonical NaN 0x7FF8000000000000, with no flag raised.
- R4: Widening is exact: normal, subnormal, zero and infinite singles map to the equal double value, and OF, UF and NX are never set.
- R5: Any NaN input yields the destination's canonical NaN (0x7FC00000 boxed, or 0x7FF8000000000000). NV (flags bit 4) is set only when the input NaN is signaling, that is, when its top fraction bit is 0.
- R6: Narrowing rounds by mode: 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, 100 nearest with ties away from zero. NX (bit 0) is set whenever the result differs from the exact value.
- R7: A rounding mode of 111 takes the mode from the frm input. The reserved values 101 and 110, whether they come from rm or from frm, behave as nearest-even.
- R8: When narrowing overflows, OF (bit 2) and NX are set. The result is the largest finite value of the operand's sign for round-toward-zero, for a positive value rounded down, and for a negative value rounded up. In every other case the result is infinity.
- R9: Narrowed values below 2^-126 are denormalised and rounded at the 2^-149 quantum. This includes double subnormals. Tininess is judged before rounding, and UF (bit 1) is set when the value is tiny and the result is inexact.
- R10: The flags vector is {NV, DZ, OF, UF, NX}, from bit 4 down to bit 0. DZ is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opIn | input | 64 | Source operand. A single value sits in bits 31:0 with a box in bits 63:32 |
| srcType | input | 5 | Source type from the rs2 field (0 = single, 1 = double) |
| dstFmt | input | 2 | Destination format from the fmt field (00 = single, 01 = double) |
| rm | input | 3 | Instruction rounding mode, where 111 selects frm |
| frm | input | 3 | Dynamic rounding mode |
| resOut | output | 64 | Converted result, with a single result boxed |
| flagsOut | output | 5 | Exception flags {NV, DZ, OF, UF, NX} |

## Verification
The narrowing direction is driven with doubles whose exponents are chosen in four bands:
- Uniform exponents reach NaN, infinity and the double subnormals.
- A band around the single subnormal boundary separates denormalisation from normal rounding and shows where UF is raised.
- A band near the top of the single range separates overflow saturation from a rounding carry into the exponent.
- A band around unit magnitude exercises plain rounding.

Fractions are often forced to an exact half-ulp tail, so nearest-even and ties-away give different answers. Every rounding mode, including the dynamic and reserved codes, is mixed in.

Widening is driven with well-boxed singles across all exponents, including subnormals. Badly boxed operands are also applied, so the canonical-NaN substitution cannot be confused with a normal conversion. Mismatched field pairs check the inert case.

// File: rtl/fpFmtCvtPkg.sv
package fpFmtCvtPkg;
  localparam int SGL_W      = 32;
  localparam int DBL_W      = 64;
  localparam int SGL_EXP_W  = 8;
  localparam int SGL_FRAC_W = 23;
  localparam int DBL_EXP_W  = 11;
  localparam int DBL_FRAC_W = 52;
  localparam int FLAG_W     = 5;
  localparam int BOX_W      = DBL_W - SGL_W;
  localparam int SIG_W      = DBL_FRAC_W + 1;
  localparam int PAD_W      = 32;
  localparam int SHIFT_W    = SIG_W + PAD_W;
  localparam int DROP_W     = DBL_FRAC_W - SGL_FRAC_W;
  localparam int XEXP_W     = 12;
  localparam int BIAS_DIFF  = 896;

  localparam int FLG_NV = 4;
  localparam int FLG_DZ = 3;
  localparam int FLG_OF = 2;
  localparam int FLG_UF = 1;
  localparam int FLG_NX = 0;

  localparam logic [SGL_W-1:0] CANON_S = 32'h7FC0_0000;
  localparam logic [DBL_W-1:0] CANON_D = 64'h7FF8_0000_0000_0000;

  typedef enum logic [2:0] {
    RM_RNE = 3'd0,
    RM_RTZ = 3'd1,
    RM_RDN = 3'd2,
    RM_RUP = 3'd3,
    RM_RMM = 3'd4
  } rndModeT;

  typedef struct packed {
    logic    doWiden;
    logic    doNarrow;
    rndModeT mode;
  } ctrlT;
endpackage

// File: rtl/fpFmtCvtCtrl.sv
module fpFmtCvtCtrl
  import fpFmtCvtPkg::*;
(
  input  logic [4:0] srcType,
  input  logic [1:0] dstFmt,
  input  logic [2:0] rm,
  input  logic [2:0] frm,
  output ctrlT       ctrl
);
  logic [2:0] effRm;

  always_comb begin
    effRm = (rm == 3'b111) ? frm : rm;
    ctrl.doWiden  = (srcType == 5'd0) && (dstFmt == 2'b01);
    ctrl.doNarrow = (srcType == 5'd1) && (dstFmt == 2'b00);
    case (effRm)
      3'd1:    ctrl.mode = RM_RTZ;
      3'd2:    ctrl.mode = RM_RDN;
      3'd3:    ctrl.mode = RM_RUP;
      3'd4:    ctrl.mode = RM_RMM;
      default: ctrl.mode = RM_RNE;
    endcase
  end
endmodule

// File: rtl/fpFmtCvtDp.sv
module fpFmtCvtDp
  import fpFmtCvtPkg::*;
(
  input  logic [DBL_W-1:0]  opIn,
  input  ctrlT              ctrl,
  output logic [DBL_W-1:0]  resOut,
  output logic [FLAG_W-1:0] flagsOut
);
  function automatic logic [4:0] lzc23(input logic [SGL_FRAC_W-1:0] v);
    lzc23 = 5'd23;
    for (int i = 0; i < SGL_FRAC_W; i++)
      if (v[i]) lzc23 = 5'(SGL_FRAC_W - 1 - i);
  endfunction

  // ---------------- widening path ----------------
  logic                  boxOk;
  logic [SGL_W-1:0]      sIn;
  logic                  wSign;
  logic [SGL_EXP_W-1:0]  wExpIn;
  logic [SGL_FRAC_W-1:0] wFrac, normFrac;
  logic [4:0]            lz;
  logic [DBL_W-1:0]      wideRes;
  logic [FLAG_W-1:0]     wideFlags;

  always_comb begin
    boxOk    = &opIn[DBL_W-1:SGL_W];
    sIn      = boxOk ? opIn[SGL_W-1:0] : CANON_S;
    wSign    = sIn[SGL_W-1];
    wExpIn   = sIn[SGL_W-2:SGL_FRAC_W];
    wFrac    = sIn[SGL_FRAC_W-1:0];
    lz       = lzc23(wFrac);
    normFrac = wFrac << (lz + 5'd1);
    wideFlags = '0;
    if (wExpIn == '1) begin
      if (wFrac != '0) begin
        wideRes = CANON_D;
        wideFlags[FLG_NV] = ~wFrac[SGL_FRAC_W-1];
      end else begin
        wideRes = {wSign, {DBL_EXP_W{1'b1}}, {DBL_FRAC_W{1'b0}}};
      end
    end else if (wExpIn == '0) begin
      if (wFrac == '0)
        wideRes = {wSign, {(DBL_W-1){1'b0}}};
      else
        wideRes = {wSign, DBL_EXP_W'(BIAS_DIFF) - DBL_EXP_W'(lz),
                   normFrac, {DROP_W{1'b0}}};
    end else begin
      wideRes = {wSign, DBL_EXP_W'(wExpIn) + DBL_EXP_W'(BIAS_DIFF),
                 wFrac, {DROP_W{1'b0}}};
    end
  end

  // ---------------- narrowing path ----------------
  logic                  nSign;
  logic [DBL_EXP_W-1:0]  nExpIn, nExpEff;
  logic [DBL_FRAC_W-1:0] nFrac;
  logic [SIG_W-1:0]      sig;
  logic signed [12:0]    eUnb, dRaw;
  logic [4:0]            dAmt;
  logic [SHIFT_W-1:0]    shifted;
  logic [SGL_FRAC_W:0]   kept;
  logic                  guardBit, stickyBit, inexact, incBit, tiny, ovf, toMax;
  logic [XEXP_W-1:0]     expPre;
  logic [XEXP_W+SGL_FRAC_W-1:0] rndSum;
  logic [SGL_W-1:0]      narrowRes;
  logic [FLAG_W-1:0]     narrowFlags;

  always_comb begin
    nSign   = opIn[DBL_W-1];
    nExpIn  = opIn[DBL_W-2:DBL_FRAC_W];
    nFrac   = opIn[DBL_FRAC_W-1:0];
    nExpEff = (nExpIn == '0) ? DBL_EXP_W'(1) : nExpIn;
    sig     = {nExpIn != '0, nFrac};
    eUnb    = $signed({2'b00, nExpEff}) - 13'sd896;
    dRaw    = 13'sd1 - eUnb;
    if (eUnb > 13'sd0)       dAmt = 5'd0;
    else if (dRaw > 13'sd31) dAmt = 5'd31;
    else                     dAmt = dRaw[4:0];
    tiny      = (dAmt != 5'd0);
    shifted   = {sig, {PAD_W{1'b0}}} >> dAmt;
    kept      = shifted[SHIFT_W-1 -: SGL_FRAC_W+1];
    guardBit  = shifted[SHIFT_W-SGL_FRAC_W-2];
    stickyBit = |shifted[SHIFT_W-SGL_FRAC_W-3:0];
    inexact   = guardBit | stickyBit;
    expPre    = (eUnb > 13'sd0) ? eUnb[XEXP_W-1:0] : '0;
    case (ctrl.mode)
      RM_RTZ:  incBit = 1'b0;
      RM_RDN:  incBit = nSign & inexact;
      RM_RUP:  incBit = ~nSign & inexact;
      RM_RMM:  incBit = guardBit;
      default: incBit = guardBit & (stickyBit | kept[0]);
    endcase
    rndSum = {expPre, kept[SGL_FRAC_W-1:0]} + (XEXP_W+SGL_FRAC_W)'(incBit);
    ovf    = rndSum[XEXP_W+SGL_FRAC_W-1:SGL_FRAC_W] >= XEXP_W'(255);
    toMax  = (ctrl.mode == RM_RTZ) || (ctrl.mode == RM_RDN && !nSign) ||
             (ctrl.mode == RM_RUP && nSign);
    narrowFlags = '0;
    if (nExpIn == '1) begin
      if (nFrac != '0) begin
        narrowRes = CANON_S;
        narrowFlags[FLG_NV] = ~nFrac[DBL_FRAC_W-1];
      end else begin
        narrowRes = {nSign, {SGL_EXP_W{1'b1}}, {SGL_FRAC_W{1'b0}}};
      end
    end else if (ovf) begin
      narrowRes = toMax ? {nSign, 8'hFE, {SGL_FRAC_W{1'b1}}}
                        : {nSign, 8'hFF, {SGL_FRAC_W{1'b0}}};
      narrowFlags[FLG_OF] = 1'b1;
      narrowFlags[FLG_NX] = 1'b1;
    end else begin
      narrowRes = {nSign, rndSum[SGL_W-2:0]};
      narrowFlags[FLG_NX] = inexact;
      narrowFlags[FLG_UF] = tiny & inexact;
    end
  end

  // ---------------- output select ----------------
  always_comb begin
    if (ctrl.doWiden) begin
      resOut   = wideRes;
      flagsOut = wideFlags;
    end else if (ctrl.doNarrow) begin
      resOut   = {{BOX_W{1'b1}}, narrowRes};
      flagsOut = narrowFlags;
    end else begin
      resOut   = '0;
      flagsOut = '0;
    end
  end
endmodule

// File: rtl/fpFmtCvt.sv
module fpFmtCvt
  import fpFmtCvtPkg::*;
(
  input  logic [63:0] opIn,
  input  logic [4:0]  srcType,
  input  logic [1:0]  dstFmt,
  input  logic [2:0]  rm,
  input  logic [2:0]  frm,
  output logic [63:0] resOut,
  output logic [4:0]  flagsOut
);
  ctrlT ctrl;

  fpFmtCvtCtrl u_ctrl (
    .srcType (srcType),
    .dstFmt  (dstFmt),
    .rm      (rm),
    .frm     (frm),
    .ctrl    (ctrl)
  );

  fpFmtCvtDp u_dp (
    .opIn     (opIn),
    .ctrl     (ctrl),
    .resOut   (resOut),
    .flagsOut (flagsOut)
  );
endmodule

// File: rtl/fpFmtCvtChk.sv
module fpFmtCvtChk (
  input logic [63:0] opIn,
  input logic [4:0]  srcType,
  input logic [1:0]  dstFmt,
  input logic [2:0]  rm,
  input logic [2:0]  frm,
  input logic [63:0] resOut,
  input logic [4:0]  flagsOut
);
  logic widenSel, narrowSel;
  assign widenSel  = (srcType == 5'd0) && (dstFmt == 2'b01);
  assign narrowSel = (srcType == 5'd1) && (dstFmt == 2'b00);

  always_comb begin
    if (!$isunknown({opIn, srcType, dstFmt, rm, frm, resOut, flagsOut})) begin
      // R1
      inert_pair_chk: assert (widenSel || narrowSel ||
                              (resOut == 64'd0 && flagsOut == 5'd0))
        else $error("inert field pair produced output");
      // R2
      narrow_box_chk: assert (!narrowSel || resOut[63:32] == 32'hFFFF_FFFF)
        else $error("narrowed result not boxed");
      // R3
      bad_box_chk: assert (!(widenSel && !(&opIn[63:32])) ||
                           (resOut == 64'h7FF8_0000_0000_0000 && flagsOut == 5'd0))
        else $error("bad box not replaced by canonical NaN");
      // R4
      widen_exact_chk: assert (!widenSel || flagsOut[2:0] == 3'b000)
        else $error("widening raised a rounding flag");
      // R5
      invalid_nan_chk: assert (!flagsOut[4] ||
                               resOut == 64'h7FF8_0000_0000_0000 ||
                               resOut == 64'hFFFF_FFFF_7FC0_0000)
        else $error("NV without canonical NaN result");
      // R8
      overflow_nx_chk: assert (!flagsOut[2] || flagsOut[0])
        else $error("OF without NX");
      // R9
      underflow_nx_chk: assert (!flagsOut[1] || flagsOut[0])
        else $error("UF without NX");
      // R10
      no_divzero_chk: assert (!flagsOut[3])
        else $error("DZ raised");
    end
  end
endmodule

bind fpFmtCvt fpFmtCvtChk u_chk (
  .opIn     (opIn),
  .srcType  (srcType),
  .dstFmt   (dstFmt),
  .rm       (rm),
  .frm      (frm),
  .resOut   (resOut),
  .flagsOut (flagsOut)
);

// File: tb/fpFmtCvt_tb.sv
module fpFmtCvt_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] opIn;
  logic [4:0]  srcType;
  logic [1:0]  dstFmt;
  logic [2:0]  rm, frm;
  logic [63:0] resOut;
  logic [4:0]  flagsOut;
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  fpFmtCvt u_dut (
    .opIn(opIn), .srcType(srcType), .dstFmt(dstFmt), .rm(rm), .frm(frm),
    .resOut(resOut), .flagsOut(flagsOut)
  );

  // Reference narrowing: bit-serial shift, returns {flags, result}
  function automatic logic [68:0] refNarrow(input logic [63:0] a, input int md);
    logic s; int e; logic [51:0] f; logic [63:0] sg; int ex, k;
    bit g, st, nx, up, tiny, of; logic [31:0] r; logic [4:0] fl;
    s = a[63]; e = int'(a[62:52]); f = a[51:0]; fl = 5'd0;
    if (e == 2047) begin
      if (f != 0) begin
        fl[4] = ~f[51];
        return {fl, 64'hFFFF_FFFF_7FC0_0000};
      end
      return {fl, 32'hFFFF_FFFF, s, 31'h7F80_0000};
    end
    if (e == 0 && f == 0) return {fl, 32'hFFFF_FFFF, s, 31'd0};
    sg = {11'd0, e != 0, f};
    ex = (e == 0) ? -1022 : e - 1023;
    tiny = ex < -126;
    k = tiny ? (-97 - ex) : 29;
    if (k > 80) k = 80;
    g = 0; st = 0;
    for (int i = 0; i < k; i++) begin st |= g; g = sg[0]; sg = sg >> 1; end
    nx = g | st;
    case (md)
      1: up = 0;
      2: up = s & nx;
      3: up = !s & nx;
      4: up = g;
      default: up = g & (st | sg[0]);
    endcase
    sg = sg + 64'(up);
    of = 0;
    if (!tiny) begin
      ex = ex + 127;
      if (sg[24]) ex = ex + 1;
      if (ex >= 255) begin
        of = 1;
        if (md == 1 || (md == 2 && !s) || (md == 3 && s)) r = {s, 8'hFE, 23'h7FFFFF};
        else r = {s, 8'hFF, 23'd0};
      end else r = {s, 8'(ex), sg[22:0]};
    end else r = {s, sg[30:0]};
    fl[2] = of; fl[0] = nx | of; fl[1] = tiny & nx & !of;
    return {fl, 32'hFFFF_FFFF, r};
  endfunction

  // Reference widening through real arithmetic
  function automatic logic [68:0] refWiden(input logic [63:0] a);
    logic [31:0] x; logic s; int e; logic [22:0] f; real v; logic [63:0] r;
    logic [4:0] fl;
    fl = 5'd0;
    x = (a[63:32] == 32'hFFFF_FFFF) ? a[31:0] : 32'h7FC0_0000;
    s = x[31]; e = int'(x[30:23]); f = x[22:0];
    if (e == 255) begin
      if (f != 0) begin fl[4] = ~f[22]; return {fl, 64'h7FF8_0000_0000_0000}; end
      return {fl, s, 63'h7FF0_0000_0000_0000};
    end
    if (e == 0) v = real'(f) * (2.0 ** (-149));
    else v = (real'(f) + 8388608.0) * (2.0 ** (e - 150));
    r = $realtobits(v);
    r[63] = s;
    return {fl, r};
  endfunction

  task automatic apply(input string tag, input logic [4:0] st, input logic [1:0] df,
                       input logic [2:0] r, input logic [2:0] fr, input logic [63:0] a);
    logic [68:0] ex; int md;
    md = (r == 3'd7) ? int'(fr) : int'(r);
    if (md > 4) md = 0;
    if (st == 5'd1 && df == 2'b00) ex = refNarrow(a, md);
    else if (st == 5'd0 && df == 2'b01) ex = refWiden(a);
    else ex = '0;
    @(posedge clk);
    opIn <= a; srcType <= st; dstFmt <= df; rm <= r; frm <= fr;
    @(negedge clk);
    nChecks++;
    if (resOut !== ex[63:0] || flagsOut !== ex[68:64]) begin
      nFails++;
      $display("FAIL %s op=%h rm=%0d frm=%0d: actual %h/%b expected %h/%b",
               tag, a, r, fr, resOut, flagsOut, ex[63:0], ex[68:64]);
    end
  endtask

  task automatic narrow(input string tag, input logic [2:0] r, input logic [63:0] a);
    apply(tag, 5'd1, 2'b00, r, 3'd0, a);
  endtask

  task automatic widen(input string tag, input logic [63:0] a);
    apply(tag, 5'd0, 2'b01, 3'd0, 3'd0, a);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seedDummy;
    logic [63:0] a;
    logic [10:0] ed;
    logic [7:0]  es;
    opIn = '0; srcType = '0; dstFmt = '0; rm = '0; frm = '0;
    seedDummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1: idle pattern after reset is inert
    @(negedge clk);
    nChecks++;
    if (resOut !== 64'd0 || flagsOut !== 5'd0) begin
      nFails++;
      $display("FAIL R1 reset state: actual %h/%b expected 0/0", resOut, flagsOut);
    end
    // R1: other field pairs are inert
    apply("R1", 5'd0, 2'b00, 3'd0, 3'd0, 64'h3FF0_0000_0000_0000);
    apply("R1", 5'd1, 2'b01, 3'd0, 3'd0, 64'h3FF0_0000_0000_0000);
    apply("R1", 5'd2, 2'b00, 3'd0, 3'd0, 64'h3FF0_0000_0000_0000);
    // R2: plain narrowing, boxed result
    narrow("R2", 3'd0, 64'h3FF0_0000_0000_0000);
    narrow("R2", 3'd0, 64'hC000_0000_0000_0000);
    // R6: tie cases, all modes
    for (int m = 0; m < 5; m++) begin
      narrow("R6", 3'(m), 64'h3FF0_0000_1000_0000);
      narrow("R6", 3'(m), 64'hBFF0_0000_3000_0000);
    end
    // R7: dynamic and reserved modes
    apply("R7", 5'd1, 2'b00, 3'd7, 3'd3, 64'h3FF0_0000_1000_0000);
    apply("R7", 5'd1, 2'b00, 3'd5, 3'd3, 64'h3FF0_0000_1000_0000);
    apply("R7", 5'd1, 2'b00, 3'd7, 3'd6, 64'h3FF0_0000_3000_0000);
    // R8: overflow by mode and sign
    for (int m = 0; m < 5; m++) begin
      narrow("R8", 3'(m), 64'h7FEF_FFFF_FFFF_FFFF);
      narrow("R8", 3'(m), 64'hFFEF_FFFF_FFFF_FFFF);
      narrow("R8", 3'(m), 64'h47EF_FFFF_F000_0000);
    end
    // R9: subnormal results and double subnormals
    for (int m = 0; m < 5; m++) begin
      narrow("R9", 3'(m), 64'h36A0_0000_0000_0000);
      narrow("R9", 3'(m), 64'h3690_0000_0000_0000);
      narrow("R9", 3'(m), 64'h0000_0000_0000_0001);
      narrow("R9", 3'(m), 64'h380F_FFFF_FFFF_FFFF);
    end
    // R5: NaNs both ways
    narrow("R5", 3'd0, 64'h7FF0_0000_0000_0001);
    narrow("R5", 3'd0, 64'hFFF8_0000_0000_1234);
    widen("R5", 64'hFFFF_FFFF_7F80_0001);
    widen("R5", 64'hFFFF_FFFF_FFC0_0005);
    // R3: bad boxes
    widen("R3", 64'h0000_0000_3F80_0000);
    widen("R3", 64'hFFFF_FFFE_7F80_0001);
    // R4: exact widening
    widen("R4", 64'hFFFF_FFFF_3F80_0000);
    widen("R4", 64'hFFFF_FFFF_0000_0001);
    widen("R4", 64'hFFFF_FFFF_807F_FFFF);
    widen("R4", 64'hFFFF_FFFF_FF80_0000);
    widen("R4", 64'hFFFF_FFFF_8000_0000);
    // R10: zero narrowing keeps flags clear
    narrow("R10", 3'd2, 64'h8000_0000_0000_0000);
    // random narrowing
    for (int i = 0; i < 3000; i++) begin
      case ($urandom % 4)
        0: ed = 11'($urandom);
        1: ed = 11'(860 + $urandom % 40);
        2: ed = 11'(1140 + $urandom % 20);
        default: ed = 11'(993 + $urandom % 60);
      endcase
      a = {1'($urandom), ed, 20'($urandom), 32'($urandom)};
      if ($urandom % 4 == 0) a[28:0] = 29'h1000_0000;
      apply("R6", 5'd1, 2'b00, 3'($urandom), 3'($urandom), a);
    end
    // random widening
    for (int i = 0; i < 2000; i++) begin
      es = ($urandom % 4 == 0) ? 8'd0 : 8'($urandom);
      a = {32'hFFFF_FFFF, 1'($urandom), es, 23'($urandom)};
      if ($urandom % 8 == 0) a[63:32] = 32'($urandom);
      widen("R4", a);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule